// File: doc/BRIEF.md
# Aligned Configuration Access Bridge

The bridge takes configuration reads and writes of one, two or four bytes from a requester and carries them out on a two-register configuration port: an address register, which selects a bus, device, function and aligned 32-bit register, and a data register, which moves that whole word. Every data-register access is a complete aligned 32-bit transfer. A narrow read takes its bytes out of the returned word. A narrow write becomes a read-modify-write: the current word is fetched, the target byte lanes are replaced, and the word is written back.

The requester drives a one-cycle request with size, location and write data. It watches `busy` and waits for the one-cycle `done` pulse, which carries `err` and, for reads, `rdata`. Only one request is in flight at a time. The address-write, read, merge and write steps of a request run without interruption. Requests with a bad size, an out-of-range offset or a misaligned offset are refused without touching the port.

Top module: `cfg_access_bridge`

## Requirements
- R1: Every address-register write carries the word {1'b1, 7'b0, bus[7:0], device[4:0], function[2:0], offset[7:2], 2'b00}, which puts enable at bit 31, bus at 23:16, device at 15:11, function at 10:8 and the word-aligned offset at 7:0.
- R2: A read (size code 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes) makes exactly one address write followed by one data read. `rdata` is the read word shifted right by 8 × offset[1:0] and kept to 8, 16 or 32 bits, with byte lane 0 at bits 7:0 (little-endian).
- R3: A 1- or 2-byte write makes the port sequence address write, data read, address write, data write. The written word is the read word with lane mask 0xFF or 0xFFFF shifted left by 8 × offset[1:0] cleared, ORed with the new value shifted the same way. Every other byte is kept.
- R4: A 4-byte write makes an address write followed by one data write of the new value, with no data read.
- R5: Offsets above 255 (1 byte), 254 (2 bytes) or 252 (4 bytes) are rejected. `done` and `err` are then high in the cycle after the request, and there is no port access.
- R6: A 2-byte access with offset[1:0] = 3, a 4-byte access with offset[1:0] ≠ 0, and size code 11 are rejected in the same way as R5.
- R7: `busy` is high from the cycle after an accepted request until `done`. `done` follows the clock edge that completes the last port transfer. Requests presented while busy are ignored.
- R8: Port handshake: a transfer completes on a clock edge with `port_req` and `port_ack` both high. Until then, `port_sel` (0 = address register, 1 = data register), `port_we` and `port_wdata` are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = invalid |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 9 | Byte offset in configuration space |
| req_wdata | input | 32 | Write value, right-aligned |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Invalid-argument flag, valid with done |
| rdata | output | 32 | Read result, valid with done, zero for writes and errors |
| port_req | output | 1 | Port transfer request |
| port_sel | output | 1 | 0 = address register, 1 = data register |
| port_we | output | 1 | 1 = write transfer |
| port_wdata | output | 32 | Port write word |
| port_ack | input | 1 | Port transfer completes this edge |
| port_rdata | input | 32 | Data register contents, valid with port_ack on reads |

## Verification
A rejected request is due at once: `done` and `err` are sampled at the falling edge right after the accepting clock edge, and the bench confirms that no port transfer was recorded. An accepted request finishes one edge after its last acknowledged transfer. Because the bench's port model stalls `port_ack` on every third cycle, the bench does not count a fixed number of cycles. It waits for `done` at falling edges and then checks that the edge just before had a completed transfer. The recorded port trace and the read result are then compared with sequences and values the bench works out from the size, offset and its own copy of the configuration words.

// File: rtl/cab_pkg.sv
package cab_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR1 = 3'd1,
    ST_RD    = 3'd2,
    ST_ADDR2 = 3'd3,
    ST_WR    = 3'd4
  } state_e;
endpackage

// File: rtl/cab_check.sv
module cab_check #(
  parameter int OFF_W = 9
) (
  input  cab_pkg::size_e    size,
  input  logic [OFF_W-1:0]  off,
  output logic              bad
);
  import cab_pkg::*;
  localparam logic [OFF_W-1:0] LIM_B = OFF_W'(255);
  localparam logic [OFF_W-1:0] LIM_H = OFF_W'(254);
  localparam logic [OFF_W-1:0] LIM_W = OFF_W'(252);

  always_comb begin
    unique case (size)
      SZ_BYTE: bad = (off > LIM_B);
      SZ_HALF: bad = (off > LIM_H) || (off[1:0] == 2'b11);
      SZ_WORD: bad = (off > LIM_W) || (off[1:0] != 2'b00);
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/cab_lanes.sv
module cab_lanes #(
  parameter int DW = 32
) (
  input  cab_pkg::size_e  size,
  input  logic [1:0]      lane,
  input  logic [DW-1:0]   word_in,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rd_val,
  output logic [DW-1:0]   merged
);
  import cab_pkg::*;
  localparam int SH_W = $clog2(DW);

  logic [SH_W-1:0] sh;
  logic [DW-1:0]   keep_mask;
  logic [DW-1:0]   shifted;
  logic [DW-1:0]   lane_mask;

  assign sh = SH_W'({lane, 3'b000});

  always_comb begin
    unique case (size)
      SZ_BYTE: keep_mask = DW'(32'h0000_00FF);
      SZ_HALF: keep_mask = DW'(32'h0000_FFFF);
      default: keep_mask = '1;
    endcase
  end

  assign shifted   = word_in >> sh;
  assign rd_val    = shifted & keep_mask;
  assign lane_mask = keep_mask << sh;
  assign merged    = (size == SZ_WORD) ? wdata
                   : ((word_in & ~lane_mask) | ((wdata & keep_mask) << sh));

  always_comb begin
    if (size == SZ_BYTE || size == SZ_HALF)
      AST_LANE_KEEP: assert (((merged ^ word_in) & ~lane_mask) == '0); // R3
  end
endmodule

// File: rtl/cab_addr_fmt.sv
module cab_addr_fmt #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic [7:0]       off,
  output logic [31:0]      word
);
  localparam int PAD_W = 23 - BUS_W - DEV_W - FN_W;

  assign word = {1'b1, {PAD_W{1'b0}}, bus, dev, fn, off[7:2], 2'b00};
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int OFF_W = 9,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [FN_W-1:0]  req_fn,
  input  logic [OFF_W-1:0] req_off,
  input  logic [DW-1:0]    req_wdata,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [DW-1:0]    rdata,
  output logic             port_req,
  output logic             port_sel,
  output logic             port_we,
  output logic [DW-1:0]    port_wdata,
  input  logic             port_ack,
  input  logic [DW-1:0]    port_rdata
);
  import cab_pkg::*;

  state_e        state;
  size_e         size_q;
  logic [1:0]    lane_q;
  logic          wr_q;
  logic [DW-1:0] wdata_q;
  logic [31:0]   aw_q;
  logic [DW-1:0] wbuf_q;
  logic [DW-1:0] rdata_q;
  logic          busy_q, done_q, err_q;
  logic          addr_fresh;

  logic          req_bad;
  logic [31:0]   aw_new;
  logic [DW-1:0] rd_val, merged;
  logic          xfer;

  cab_check #(.OFF_W(OFF_W)) u_check (
    .size (size_e'(req_size)),
    .off  (req_off),
    .bad  (req_bad)
  );

  cab_addr_fmt #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W)) u_fmt (
    .bus  (req_bus),
    .dev  (req_dev),
    .fn   (req_fn),
    .off  (req_off[7:0]),
    .word (aw_new)
  );

  cab_lanes #(.DW(DW)) u_lanes (
    .size    (size_q),
    .lane    (lane_q),
    .word_in (port_rdata),
    .wdata   (wdata_q),
    .rd_val  (rd_val),
    .merged  (merged)
  );

  assign xfer = port_req && port_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      size_q  <= SZ_BYTE;
      lane_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      aw_q    <= '0;
      wbuf_q  <= '0;
      rdata_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_bad) begin
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '0;
            end else begin
              busy_q  <= 1'b1;
              size_q  <= size_e'(req_size);
              lane_q  <= req_off[1:0];
              wr_q    <= req_write;
              wdata_q <= req_wdata;
              wbuf_q  <= req_wdata;
              aw_q    <= aw_new;
              state   <= (req_write && size_e'(req_size) == SZ_WORD) ? ST_ADDR2 : ST_ADDR1;
            end
          end
        end
        ST_ADDR1: if (port_ack) state <= ST_RD;
        ST_RD: begin
          if (port_ack) begin
            if (wr_q) begin
              wbuf_q <= merged;
              state  <= ST_ADDR2;
            end else begin
              rdata_q <= rd_val;
              err_q   <= 1'b0;
              done_q  <= 1'b1;
              busy_q  <= 1'b0;
              state   <= ST_IDLE;
            end
          end
        end
        ST_ADDR2: if (port_ack) state <= ST_WR;
        ST_WR: begin
          if (port_ack) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Tracks that an address write has completed within the current request.
  always_ff @(posedge clk) begin
    if (rst)                     addr_fresh <= 1'b0;
    else if (done_q)             addr_fresh <= 1'b0;
    else if (xfer && !port_sel)  addr_fresh <= 1'b1;
  end

  assign port_req   = (state != ST_IDLE);
  assign port_sel   = (state == ST_RD) || (state == ST_WR);
  assign port_we    = (state != ST_RD);
  assign port_wdata = port_sel ? wbuf_q : aw_q;

  assign busy  = busy_q;
  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rdata_q;

  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (rst)
    (port_req && !port_sel) |-> (port_we && port_wdata[31] && port_wdata[1:0] == 2'b00)); // R1
  AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
    (xfer && port_sel) |-> addr_fresh); // R3
  AST_ERR_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> !$past(busy)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !port_req)); // R7
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (port_req && !port_ack) |=> (port_req && $stable(port_sel) && $stable(port_we) && $stable(port_wdata))); // R8
endmodule

// File: tb/sim_cfg_access_bridge.sv
`timescale 1ns/1ps
module sim_cfg_access_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [8:0]  req_off = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        port_req, port_sel, port_we, port_ack;
  logic [31:0] port_wdata, port_rdata;

  int tests = 0, fails = 0, cyc = 0;
  logic [31:0] mem [512];
  logic [31:0] areg = '0;
  logic        xfer_prev = 1'b0;
  logic        tr_sel [16];
  logic        tr_we  [16];
  logic [31:0] tr_dat [16];
  int          tr_total = 0;

  always #4 clk = ~clk;

  cfg_access_bridge u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
    .req_off(req_off), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .port_req(port_req), .port_sel(port_sel),
    .port_we(port_we), .port_wdata(port_wdata), .port_ack(port_ack),
    .port_rdata(port_rdata)
  );

  function automatic int idx_of(input logic [31:0] a);
    return int'({a[16], a[11], a[8], a[7:2]});
  endfunction

  assign port_ack   = port_req && ((cyc % 3) != 2);
  assign port_rdata = mem[idx_of(areg)];

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'hA5C3_0F1E;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    xfer_prev <= port_req && port_ack;
    if (port_req && port_ack) begin
      tr_sel[tr_total % 16] <= port_sel;
      tr_we[tr_total % 16]  <= port_we;
      tr_dat[tr_total % 16] <= port_we ? port_wdata : port_rdata;
      tr_total <= tr_total + 1;
      if (!port_sel && port_we) areg <= port_wdata;
      if (port_sel && port_we)  mem[idx_of(areg)] <= port_wdata;
    end
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input logic [1:0] sz, input logic [7:0] b,
                        input logic [4:0] d, input logic [2:0] f,
                        input logic [8:0] off, input logic [31:0] wd, input bit intrude);
    bit          bad;
    logic [31:0] a, old, exp_rd, m, mrg, w;
    int          t0, n_exp, k;
    logic [4:0]  sh;
    bit          sel_e [4];
    bit          we_e  [4];
    logic [31:0] dat_e [4];
    bit          seq_ok, addr_ok, dat_ok;
    string       tag;
    bad = (sz == 2'b11) || (sz == 2'b00 && off > 255) ||
          (sz == 2'b01 && (off > 254 || off[1:0] == 2'b11)) ||
          (sz == 2'b10 && (off > 252 || off[1:0] != 2'b00));
    a   = 32'h8000_0000 | (32'(b) << 16) | (32'(d) << 11) | (32'(f) << 8) | (32'(off) & 32'hFC);
    old = mem[idx_of(a)];
    sh  = {off[1:0], 3'b000};
    m   = (sz == 2'b00) ? 32'hFF : 32'hFFFF;
    w   = old >> sh;
    exp_rd = (sz == 2'b10) ? old : (w & m);
    mrg = (sz == 2'b10) ? wd : ((old & ~(m << sh)) | ((wd & m) << sh));
    t0 = tr_total;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_bus = b; req_dev = d;
    req_fn = f; req_off = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      tag = (off > 255 || (sz == 2'b01 && off > 254) || (sz == 2'b10 && off > 252)) ? "R5 range" : "R6 align";
      check(done && err, tag, {30'b0, done, err}, 32'h3);
      check(tr_total == t0, {tag, " port untouched"}, 32'(tr_total - t0), 32'h0);
      check(!busy, "R7 not busy on reject", {31'b0, busy}, 32'h0);
      return;
    end
    check(busy, "R7 busy after accept", {31'b0, busy}, 32'h1);
    if (intrude) begin
      req_valid = 1'b1; req_write = 1'b1; req_size = 2'b10; req_off = 9'h10;
      req_bus = 8'h00; req_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      check(busy && !done, "R7 intruder ignored", {30'b0, busy, done}, 32'h2);
      @(negedge clk);
      req_valid = 1'b0;
    end
    k = 0;
    while (!done && k < 300) begin
      @(negedge clk);
      k++;
    end
    check(done && !err, "R7 completion", {30'b0, done, err}, 32'h2);
    check(xfer_prev, "R7 done follows last transfer", {31'b0, xfer_prev}, 32'h1);
    if (!wr) begin
      n_exp = 2; tag = "R2 read";
      sel_e[0] = 0; we_e[0] = 1; dat_e[0] = a;
      sel_e[1] = 1; we_e[1] = 0; dat_e[1] = old;
      check(rdata == exp_rd, "R2 read value", rdata, exp_rd);
    end else if (sz == 2'b10) begin
      n_exp = 2; tag = "R4 word write";
      sel_e[0] = 0; we_e[0] = 1; dat_e[0] = a;
      sel_e[1] = 1; we_e[1] = 1; dat_e[1] = wd;
    end else begin
      n_exp = 4; tag = "R3 narrow write";
      sel_e[0] = 0; we_e[0] = 1; dat_e[0] = a;
      sel_e[1] = 1; we_e[1] = 0; dat_e[1] = old;
      sel_e[2] = 0; we_e[2] = 1; dat_e[2] = a;
      sel_e[3] = 1; we_e[3] = 1; dat_e[3] = mrg;
    end
    seq_ok = (tr_total - t0 == n_exp);
    addr_ok = 1'b1; dat_ok = 1'b1;
    if (seq_ok) begin
      for (int i = 0; i < n_exp; i++) begin
        if (tr_sel[(t0 + i) % 16] != sel_e[i] || tr_we[(t0 + i) % 16] != we_e[i]) seq_ok = 0;
        if (!sel_e[i] && tr_dat[(t0 + i) % 16] != a) addr_ok = 0;
        if (sel_e[i] && tr_dat[(t0 + i) % 16] != dat_e[i]) dat_ok = 0;
      end
    end
    check(seq_ok, {tag, " sequence"}, 32'(tr_total - t0), 32'(n_exp));
    check(addr_ok, "R1 address word", tr_dat[t0 % 16], a);
    check(dat_ok, {tag, " data"}, tr_dat[(t0 + n_exp - 1) % 16], dat_e[n_exp - 1]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && rdata == 0 && !port_req, "R7 reset state",
          {27'b0, busy, done, err, port_req, |rdata}, 32'h0);
    rst = 1'b0;
    // Sweep: every size code, offsets across and past each limit.
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 262; o++) begin
        logic [7:0] b; logic [4:0] d; logic [2:0] f;
        b = (o % 2) ? 8'hA5 : 8'h00;
        d = ((o / 2) % 2) ? 5'h13 : 5'h00;
        f = ((o / 4) % 2) ? 3'h5 : 3'h0;
        run_op(1'b0, 2'(s), b, d, f, 9'(o), 32'h0, 1'b0);
        run_op(1'b1, 2'(s), b, d, f, 9'(o), 32'h1357_9BDF ^ (o * 32'h0101_0101), 1'b0);
        run_op(1'b0, 2'(s), b, d, f, 9'(o), 32'h0, 1'b0);
      end
    end
    run_op(1'b0, 2'b00, 8'h00, 5'h00, 3'h0, 9'd511, 32'h0, 1'b0);
    run_op(1'b0, 2'b10, 8'h00, 5'h00, 3'h0, 9'd256, 32'h0, 1'b0);
    run_op(1'b1, 2'b00, 8'hA5, 5'h13, 3'h5, 9'd7, 32'h0000_0042, 1'b1);
    run_op(1'b1, 2'b01, 8'h00, 5'h13, 3'h0, 9'd2, 32'h0000_BEEF, 1'b1);
    run_op(1'b0, 2'b10, 8'h00, 5'h13, 3'h0, 9'd0, 32'h0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule